// File: doc/BRIEF.md
# Outstanding Request Age Watchdog

This block sits beside a request tracker that holds up to `SLOTS` in-flight memory requests. Each time the tracker accepts a request into one of its slots it pulses the allocate strobe with that slot number, and each time a request completes it pulses the retire strobe with its slot number. The watchdog records the value of a free-running cycle counter for every live slot. It compares the age of every live slot against a fixed limit and raises a sticky deadlock flag, together with the number of the slot that tripped it, as soon as one request has been waiting at least `THRESH` cycles.

The comparison is not made on every cycle. The first allocation into an empty tracker starts an inspection period of `THRESH` cycles. At the end of each period every live slot is inspected at once. If the tracker still holds anything after that inspection, a new period starts at once. If the tracker has drained, inspection stops until the next allocation. A request can therefore be flagged up to almost two periods after it was issued. This costs one shared period counter instead of a timer in every slot. At each inspection the block also compares its running count of live requests with the number of occupied slots, and raises a separate sticky flag if the two differ.

All pins are plain strobes and levels. The block never pushes back on the tracker, and neither strobe has a ready signal: every pulse is acted on in the cycle it is seen, or ignored under the rules below.

Top module: `req_age_watchdog`

## Requirements
- R1: While reset is asserted and right after it is released, `deadlock`, `deadlock_slot` and `tally_err` are all 0.
- R2: A request allocated on the same edge that starts an inspection period, and still live at its end, is flagged on the edge exactly `THRESH` cycles after its allocation edge. Its age is the cycle counter sampled on the inspection edge minus the counter sampled on its allocation edge, and it is flagged when that age is at least `THRESH`.
- R3: A request whose age is below `THRESH` at an inspection is not flagged by that inspection. It is flagged by the next inspection if it is still live then.
- R4: `deadlock` rises only on an inspection edge. These edges fall every `THRESH` cycles, counted from the allocation that armed the period, and never between them.
- R5: When an inspection finds no live requests, inspection stops. The next allocation starts a fresh period of `THRESH` cycles measured from its own edge.
- R6: A request that is retired before an inspection is never flagged.
- R7: When several requests qualify at the same inspection, `deadlock_slot` reports the lowest-numbered one. `deadlock` and `deadlock_slot` then hold their values until reset, whatever later inspections find.
- R8: Ages are computed modulo 2^`TW`, so a request issued just before the cycle counter wraps is aged correctly after the wrap. `2*THRESH` must be below 2^`TW`.
- R9: An allocate strobe naming a slot that is already live is ignored, and the slot keeps its original timestamp. A retire strobe naming a free slot is ignored. If both strobes name the same slot in one cycle, only the one that suits the slot's current state takes effect.
- R10: At every inspection the running live count must equal the number of occupied slots. A mismatch sets `tally_err`, which is sticky. In correct operation it stays 0.
- R11: `THRESH` must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | A request entered the tracker this cycle |
| alloc_slot | input | $clog2(SLOTS) | Slot of the new request |
| retire_valid | input | 1 | A request left the tracker this cycle |
| retire_slot | input | $clog2(SLOTS) | Slot of the finished request |
| cycle_now | input | TW | Free-running cycle counter |
| deadlock | output | 1 | Sticky: some request reached the age limit |
| deadlock_slot | output | $clog2(SLOTS) | Lowest slot flagged at the first tripping inspection |
| tally_err | output | 1 | Sticky: live count disagreed with occupied slots at an inspection |

## Verification
The hardest case to reach is a request that has already passed the age limit in wall-clock terms but is still not flagged, because inspections happen only on the period boundary. The stimulus allocates one slot to arm the period. A few cycles later it allocates a second slot, and then it retires the first. The bench then shows that the second slot survives the first inspection and trips the second. The same pattern is used to show that the epoch restarts after a drain. It is also replayed with the cycle counter about to wrap, so that the only correct age is the modular one.

// File: rtl/agewd_pkg.sv
package agewd_pkg;

  // Inspection scheduler state.
  typedef enum logic {
    SCH_IDLE  = 1'b0,
    SCH_ARMED = 1'b1
  } sched_state_e;

endpackage

// File: rtl/agewd_slot_bank.sv
module agewd_slot_bank #(
  parameter int SLOTS = 8,
  parameter int TW    = 16,
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [IW-1:0]        alloc_slot,
  input  logic                 retire_valid,
  input  logic [IW-1:0]        retire_slot,
  input  logic [TW-1:0]        cycle_now,
  output logic [SLOTS-1:0]     slot_live,
  output logic [SLOTS*TW-1:0]  slot_stamp,
  output logic                 alloc_take,
  output logic                 retire_take
);

  logic alloc_in_range;
  logic retire_in_range;

  assign alloc_in_range  = (32'(alloc_slot)  < SLOTS);
  assign retire_in_range = (32'(retire_slot) < SLOTS);

  // An allocation lands only on a free slot, a retire only on a live one.
  assign alloc_take  = alloc_valid  && alloc_in_range  && !slot_live[alloc_slot];
  assign retire_take = retire_valid && retire_in_range &&  slot_live[retire_slot];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic          set_here;
    logic          clr_here;
    logic [TW-1:0] stamp_q;
    logic          live_q;

    assign set_here = alloc_take  && (32'(alloc_slot)  == g);
    assign clr_here = retire_take && (32'(retire_slot) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q  <= 1'b0;
        stamp_q <= '0;
      end else if (set_here) begin
        live_q  <= 1'b1;
        stamp_q <= cycle_now;
      end else if (clr_here) begin
        live_q  <= 1'b0;
      end
    end

    assign slot_live[g]              = live_q;
    assign slot_stamp[g*TW +: TW]    = stamp_q;
  end

endmodule

// File: rtl/agewd_epoch.sv
module agewd_epoch
  import agewd_pkg::*;
#(
  parameter int SLOTS  = 8,
  parameter int THRESH = 64,
  localparam int CW    = $clog2(THRESH + 1),
  localparam int NW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_take,
  input  logic          retire_take,
  output logic          armed,
  output logic          check_fire,
  output logic [NW-1:0] live_count
);

  localparam logic [CW-1:0] PERIOD_LAST = CW'(THRESH - 1);

  sched_state_e  state_q;
  logic [CW-1:0] wait_q;
  logic [NW-1:0] count_q;
  logic [NW-1:0] count_nxt;

  always_comb begin
    count_nxt = count_q;
    if (alloc_take)  count_nxt = count_nxt + NW'(1);
    if (retire_take) count_nxt = count_nxt - NW'(1);
  end

  assign check_fire = (state_q == SCH_ARMED) && (wait_q == '0);
  assign armed      = (state_q == SCH_ARMED);
  assign live_count = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      count_q <= count_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCH_IDLE;
      wait_q  <= '0;
    end else begin
      case (state_q)
        SCH_IDLE: begin
          if (alloc_take) begin
            state_q <= SCH_ARMED;
            wait_q  <= PERIOD_LAST;
          end
        end
        default: begin
          if (check_fire) begin
            if (count_nxt != '0) begin
              wait_q <= PERIOD_LAST;
            end else begin
              state_q <= SCH_IDLE;
            end
          end else begin
            wait_q <= wait_q - CW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/agewd_scan.sv
module agewd_scan #(
  parameter int SLOTS  = 8,
  parameter int TW     = 16,
  parameter int THRESH = 64,
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NW    = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]    slot_live,
  input  logic [SLOTS*TW-1:0] slot_stamp,
  input  logic [TW-1:0]       cycle_now,
  output logic                any_old,
  output logic [IW-1:0]       first_old,
  output logic [NW-1:0]       live_ones
);

  localparam logic [TW-1:0] LIMIT = TW'(THRESH);

  logic [SLOTS-1:0] too_old;

  for (genvar g = 0; g < SLOTS; g++) begin : g_age
    logic [TW-1:0] age;
    // Modular difference handles the counter wrapping past zero.
    assign age        = cycle_now - slot_stamp[g*TW +: TW];
    assign too_old[g] = slot_live[g] && (age >= LIMIT);
  end

  always_comb begin
    first_old = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      if (too_old[k]) first_old = IW'(k);
    end
  end

  assign any_old = |too_old;

  always_comb begin
    live_ones = '0;
    for (int k = 0; k < SLOTS; k++) begin
      live_ones = live_ones + NW'(slot_live[k]);
    end
  end

endmodule

// File: rtl/req_age_watchdog.sv
module req_age_watchdog #(
  parameter int SLOTS  = 8,
  parameter int TW     = 16,
  parameter int THRESH = 64,
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [IW-1:0] alloc_slot,
  input  logic          retire_valid,
  input  logic [IW-1:0] retire_slot,
  input  logic [TW-1:0] cycle_now,
  output logic          deadlock,
  output logic [IW-1:0] deadlock_slot,
  output logic          tally_err
);

  logic [SLOTS-1:0]    slot_live;
  logic [SLOTS*TW-1:0] slot_stamp;
  logic                alloc_take;
  logic                retire_take;
  logic                armed;
  logic                check_fire;
  logic [NW-1:0]       live_count;
  logic                any_old;
  logic [IW-1:0]       first_old;
  logic [NW-1:0]       live_ones;

  agewd_slot_bank #(.SLOTS(SLOTS), .TW(TW)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .alloc_slot   (alloc_slot),
    .retire_valid (retire_valid),
    .retire_slot  (retire_slot),
    .cycle_now    (cycle_now),
    .slot_live    (slot_live),
    .slot_stamp   (slot_stamp),
    .alloc_take   (alloc_take),
    .retire_take  (retire_take)
  );

  agewd_epoch #(.SLOTS(SLOTS), .THRESH(THRESH)) u_epoch (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_take  (alloc_take),
    .retire_take (retire_take),
    .armed       (armed),
    .check_fire  (check_fire),
    .live_count  (live_count)
  );

  agewd_scan #(.SLOTS(SLOTS), .TW(TW), .THRESH(THRESH)) u_scan (
    .slot_live  (slot_live),
    .slot_stamp (slot_stamp),
    .cycle_now  (cycle_now),
    .any_old    (any_old),
    .first_old  (first_old),
    .live_ones  (live_ones)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deadlock      <= 1'b0;
      deadlock_slot <= '0;
    end else if (check_fire && any_old && !deadlock) begin
      deadlock      <= 1'b1;
      deadlock_slot <= first_old;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally_err <= 1'b0;
    end else if (check_fire && (live_count != live_ones)) begin
      tally_err <= 1'b1;
    end
  end

endmodule

// File: rtl/req_age_watchdog_chk.sv
module req_age_watchdog_chk #(
  parameter int SLOTS  = 8,
  parameter int TW     = 16,
  parameter int THRESH = 64,
  localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int NW    = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] slot_live,
  input logic [NW-1:0]    live_count,
  input logic             armed,
  input logic             check_fire,
  input logic             deadlock,
  input logic [IW-1:0]    deadlock_slot,
  input logic             tally_err
);

  initial begin
    a_r11_thresh_positive: assert (THRESH >= 1);
    a_r8_stamp_range: assert (2 * THRESH < (64'd1 << TW));
  end

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> (deadlock && $stable(deadlock_slot)));

  a_r4_rise_on_check: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> $past(check_fire));

  a_r6_rise_needs_live: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadlock) |-> ($past(live_count) != '0));

  a_r5_idle_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (live_count == '0));

  a_r10_tally_match: assert property (@(posedge clk) disable iff (!rst_n)
    check_fire |-> (32'(live_count) == $countones(slot_live)));

  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !tally_err);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(live_count) <= SLOTS);

endmodule

bind req_age_watchdog req_age_watchdog_chk #(
  .SLOTS(SLOTS), .TW(TW), .THRESH(THRESH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .slot_live     (slot_live),
  .live_count    (live_count),
  .armed         (armed),
  .check_fire    (check_fire),
  .deadlock      (deadlock),
  .deadlock_slot (deadlock_slot),
  .tally_err     (tally_err)
);

// File: tb/req_age_watchdog_tb.sv
module req_age_watchdog_tb;

  localparam int SLOTS  = 8;
  localparam int TW     = 8;
  localparam int THRESH = 20;
  localparam int IW     = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alloc_valid = 1'b0;
  logic [IW-1:0] alloc_slot = '0;
  logic          retire_valid = 1'b0;
  logic [IW-1:0] retire_slot = '0;
  logic [TW-1:0] tick = '0;
  logic          deadlock;
  logic [IW-1:0] deadlock_slot;
  logic          tally_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  always @(negedge clk) tick <= tick + 1'b1;

  req_age_watchdog #(.SLOTS(SLOTS), .TW(TW), .THRESH(THRESH)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .alloc_slot    (alloc_slot),
    .retire_valid  (retire_valid),
    .retire_slot   (retire_slot),
    .cycle_now     (tick),
    .deadlock      (deadlock),
    .deadlock_slot (deadlock_slot),
    .tally_err     (tally_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic alloc(input int s);
    alloc_valid = 1'b1;
    alloc_slot  = IW'(s);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic retire(input int s);
    retire_valid = 1'b1;
    retire_slot  = IW'(s);
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    step(2);
    chk("R1 deadlock in reset", int'(deadlock), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 deadlock after reset", int'(deadlock), 0);
    chk("R1 slot after reset", int'(deadlock_slot), 0);
    chk("R1 tally_err after reset", int'(tally_err), 0);
  endtask

  task automatic t_exact_limit();
    do_reset();
    alloc(3);
    step(THRESH - 1);
    chk("R4 no flag before inspection", int'(deadlock), 0);
    step(1);
    chk("R2 flag at age THRESH", int'(deadlock), 1);
    chk("R2 flagged slot", int'(deadlock_slot), 3);
  endtask

  task automatic t_late_entry();
    do_reset();
    alloc(0);
    step(4);
    alloc(5);
    retire(0);
    step(THRESH - 6);
    chk("R3 young request not flagged", int'(deadlock), 0);
    step(THRESH - 1);
    chk("R4 no flag between inspections", int'(deadlock), 0);
    step(1);
    chk("R3 flagged at next inspection", int'(deadlock), 1);
    chk("R3 flagged slot", int'(deadlock_slot), 5);
  endtask

  task automatic t_drain_rearm();
    do_reset();
    alloc(2);
    retire(2);
    step(THRESH + 6);
    alloc(1);
    step(THRESH - 1);
    chk("R6 retired request not flagged", int'(deadlock), 0);
    step(1);
    chk("R5 fresh period after drain", int'(deadlock), 1);
    chk("R5 flagged slot", int'(deadlock_slot), 1);
  endtask

  task automatic t_priority_sticky();
    do_reset();
    alloc(7);
    alloc(4);
    alloc(2);
    retire(7);
    step(THRESH - 3);
    chk("R3 both younger at first inspection", int'(deadlock), 0);
    step(THRESH);
    chk("R7 flag raised", int'(deadlock), 1);
    chk("R7 lowest slot chosen", int'(deadlock_slot), 2);
    retire(2);
    alloc(0);
    step(2 * THRESH + 2);
    chk("R7 flag held", int'(deadlock), 1);
    chk("R7 slot held", int'(deadlock_slot), 2);
  endtask

  task automatic t_ignored_strobes();
    do_reset();
    retire(5);
    alloc(3);
    step(THRESH - 4);
    alloc(3);
    step(2);
    chk("R9 no flag before inspection", int'(deadlock), 0);
    step(1);
    chk("R9 original stamp kept", int'(deadlock), 1);
    chk("R9 flagged slot", int'(deadlock_slot), 3);
    chk("R10 tally_err quiet", int'(tally_err), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    while (tick != TW'(240)) @(negedge clk);
    alloc(0);
    alloc(1);
    retire(0);
    step(THRESH - 2);
    chk("R8 no false flag across wrap", int'(deadlock), 0);
    step(THRESH - 1);
    chk("R8 still young before second inspection", int'(deadlock), 0);
    step(1);
    chk("R8 flagged after wrap", int'(deadlock), 1);
    chk("R8 flagged slot", int'(deadlock_slot), 1);
    chk("R10 tally_err quiet after wrap", int'(tally_err), 0);
  endtask

  initial begin
    t_reset();
    t_exact_limit();
    t_late_entry();
    t_drain_rearm();
    t_priority_sticky();
    t_ignored_strobes();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule